// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column address for each beat of a read or write burst in a row of 256 columns. When a column command is accepted, the start strobe loads the starting column, the burst length code, the ordering bit and the auto-precharge bit. From the next clock the block presents one column per clock, flags each beat as valid and marks the final beat of a fixed-length burst. When that burst ends on its own and auto-precharge was requested, the block raises a one-clock precharge request.

The controller has four states. `ST_IDLE` presents no beats. `ST_FIXED` steps through a 1, 2, 4 or 8 beat burst. `ST_PAGE` runs a full-page burst. `ST_PRECHG` holds the one-clock precharge request. The transitions are:
- start: from any state to `ST_FIXED` or `ST_PAGE`.
- terminate: from `ST_FIXED` or `ST_PAGE` to `ST_IDLE`.
- complete: from `ST_FIXED` to `ST_PRECHG` when auto-precharge was latched, otherwise to `ST_IDLE`.
- release: from `ST_PRECHG` to `ST_IDLE`.

When several of these apply on the same clock, start wins over terminate, and terminate wins over completion.

Top module: `burst_col_gen`

## Requirements
- R1: While reset is held, and on the first clock after it, `col_o` is 0 and `beat_valid_o`, `last_o` and `pre_req_o` are 0.
- R2: On the clock after `start_i` is sampled high, `beat_valid_o` is 1 and `col_o` equals the sampled `start_col_i`. Each later beat follows one clock after the previous one.
- R3: With `interleave_i`=0, `len_sel_i` codes 0, 1, 2 and 3 select 1, 2, 4 and 8 beats. Beat k has address bits above the block size equal to the start column and low bits equal to (start + k) modulo the length, so the burst wraps inside its aligned block.
- R4: With `interleave_i`=1 and a fixed length, beat k is the start column XOR k.
- R5: `len_sel_i`=7 selects full page. Addresses increase by one per clock, wrap from 255 to 0, and never end on their own.
- R6: `last_o` is 1 exactly on the final beat of a fixed-length burst. It is never 1 during a full-page burst.
- R7: On the clock after the final beat, `beat_valid_o` is 0, unless a new start was sampled.
- R8: A `term_i` sampled during a burst, with no start on that clock, makes `beat_valid_o` 0 from the next clock. A `term_i` sampled while no burst runs has no effect on any output.
- R9: A `start_i` sampled during a burst restarts the sequence from the new column. It wins over a `term_i` sampled on the same clock.
- R10: `pre_req_o` is 1 for exactly one clock, on the clock after the final beat, and only when `auto_pre_i` was 1 at the start and the burst completed without termination or restart.
- R11: The reserved `len_sel_i` codes 4, 5 and 6 behave as a single-beat burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Column command accepted; loads a new burst |
| start_col_i | input | 8 | Starting column for the burst |
| len_sel_i | input | 3 | Burst length code (0:1, 1:2, 2:4, 3:8, 7:full page) |
| interleave_i | input | 1 | 0 selects sequential order, 1 selects interleaved order |
| auto_pre_i | input | 1 | Request precharge when the burst completes |
| term_i | input | 1 | Burst terminate strobe |
| col_o | output | 8 | Column address of the current beat (0 when no beat) |
| beat_valid_o | output | 1 | A beat is presented this clock |
| last_o | output | 1 | Final beat of a fixed-length burst |
| pre_req_o | output | 1 | One-clock auto-precharge request |

## Verification
The assertions assume that `start_i` and `term_i` are clean, single-clock-sampled strobes that are 0 during reset. They also assume that `len_sel_i`, `interleave_i` and `auto_pre_i` matter only on clocks where `start_i` is high. The stimulus changes every input only on the falling edge, so each one is stable at the sampling edge. It deliberately varies the control inputs on clocks without a start, to show that they are ignored there. The stimulus also exercises strobe collisions: a terminate with a start, a start on the final beat, a start during the precharge clock, and a terminate while idle. The bench then runs a long random phase that mixes all of these cases.

// File: rtl/colgen_pkg.sv
package colgen_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FIXED  = 2'd1,
        ST_PAGE   = 2'd2,
        ST_PRECHG = 2'd3
    } cg_state_e;

    localparam logic [2:0] LEN_ONE  = 3'd0;
    localparam logic [2:0] LEN_TWO  = 3'd1;
    localparam logic [2:0] LEN_FOUR = 3'd2;
    localparam logic [2:0] LEN_EGT  = 3'd3;
    localparam logic [2:0] LEN_PAGE = 3'd7;

endpackage

// File: rtl/cg_len_decode.sv
module cg_len_decode
    import colgen_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic [2:0]       len_sel,
    output logic [COL_W-1:0] last_idx,
    output logic             is_page
);

    always_comb begin
        is_page  = 1'b0;
        last_idx = '0;
        unique case (len_sel)
            LEN_ONE:  last_idx = COL_W'(0);
            LEN_TWO:  last_idx = COL_W'(1);
            LEN_FOUR: last_idx = COL_W'(3);
            LEN_EGT:  last_idx = COL_W'(7);
            LEN_PAGE: begin
                last_idx = '1;
                is_page  = 1'b1;
            end
            default:  last_idx = COL_W'(0);
        endcase
    end

endmodule

// File: rtl/cg_col_calc.sv
module cg_col_calc #(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] idx,
    input  logic [COL_W-1:0] mask,
    input  logic             interleave,
    input  logic             page,
    output logic [COL_W-1:0] col
);

    logic [COL_W-1:0] sum_w;
    logic [COL_W-1:0] xor_w;
    logic [COL_W-1:0] low_w;
    logic [COL_W-1:0] eff_mask;

    always_comb begin
        sum_w    = base + idx;
        xor_w    = base ^ idx;
        low_w    = (interleave && !page) ? xor_w : sum_w;
        eff_mask = page ? '1 : mask;
    end

    for (genvar b = 0; b < COL_W; b++) begin : g_bit
        assign col[b] = eff_mask[b] ? low_w[b] : base[b];
    end

endmodule

// File: rtl/cg_burst_fsm.sv
module cg_burst_fsm
    import colgen_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             term_i,
    input  logic [COL_W-1:0] new_base,
    input  logic [COL_W-1:0] new_last_idx,
    input  logic             new_page,
    input  logic             new_itl,
    input  logic             new_ap,
    output logic [COL_W-1:0] base_q,
    output logic [COL_W-1:0] idx_q,
    output logic [COL_W-1:0] mask_q,
    output logic             itl_q,
    output logic             page_q,
    output logic             beat_valid_o,
    output logic             last_o,
    output logic             pre_req_o
);

    cg_state_e state_q, state_d;
    logic      ap_q;
    logic      at_end;

    assign at_end = (state_q == ST_FIXED) && (idx_q == mask_q);

    always_comb begin
        state_d = state_q;
        if (start_i) begin
            state_d = new_page ? ST_PAGE : ST_FIXED;
        end else begin
            unique case (state_q)
                ST_IDLE:   state_d = ST_IDLE;
                ST_FIXED:  begin
                    if (term_i)      state_d = ST_IDLE;
                    else if (at_end) state_d = ap_q ? ST_PRECHG : ST_IDLE;
                end
                ST_PAGE:   if (term_i) state_d = ST_IDLE;
                ST_PRECHG: state_d = ST_IDLE;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            idx_q  <= '0;
            mask_q <= '0;
            itl_q  <= 1'b0;
            page_q <= 1'b0;
            ap_q   <= 1'b0;
        end else if (start_i) begin
            base_q <= new_base;
            idx_q  <= '0;
            mask_q <= new_last_idx;
            itl_q  <= new_itl;
            page_q <= new_page;
            ap_q   <= new_ap;
        end else if (state_q == ST_FIXED || state_q == ST_PAGE) begin
            idx_q  <= idx_q + 1'b1;
        end
    end

    always_comb begin
        beat_valid_o = 1'b0;
        last_o       = 1'b0;
        pre_req_o    = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_FIXED:  begin
                beat_valid_o = 1'b1;
                last_o       = at_end;
            end
            ST_PAGE:   beat_valid_o = 1'b1;
            ST_PRECHG: pre_req_o = 1'b1;
            default:   ;
        endcase
    end

    // R6
    last_needs_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> beat_valid_o);

    // R7
    last_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && !start_i && !term_i) |=> !beat_valid_o);

    // R8
    term_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid_o && term_i && !start_i) |=> (!beat_valid_o && !pre_req_o));

    // R10
    prereq_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pre_req_o |-> $past(last_o));

    // R10
    prereq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pre_req_o |=> !pre_req_o);

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
    import colgen_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [2:0]       len_sel_i,
    input  logic             interleave_i,
    input  logic             auto_pre_i,
    input  logic             term_i,
    output logic [COL_W-1:0] col_o,
    output logic             beat_valid_o,
    output logic             last_o,
    output logic             pre_req_o
);

    logic [COL_W-1:0] dec_last;
    logic             dec_page;
    logic [COL_W-1:0] base_q, idx_q, mask_q;
    logic             itl_q, page_q;
    logic [COL_W-1:0] calc_col;

    cg_len_decode #(.COL_W(COL_W)) u_dec (
        .len_sel  (len_sel_i),
        .last_idx (dec_last),
        .is_page  (dec_page)
    );

    cg_burst_fsm #(.COL_W(COL_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .term_i       (term_i),
        .new_base     (start_col_i),
        .new_last_idx (dec_last),
        .new_page     (dec_page),
        .new_itl      (interleave_i),
        .new_ap       (auto_pre_i),
        .base_q       (base_q),
        .idx_q        (idx_q),
        .mask_q       (mask_q),
        .itl_q        (itl_q),
        .page_q       (page_q),
        .beat_valid_o (beat_valid_o),
        .last_o       (last_o),
        .pre_req_o    (pre_req_o)
    );

    cg_col_calc #(.COL_W(COL_W)) u_calc (
        .base       (base_q),
        .idx        (idx_q),
        .mask       (mask_q),
        .interleave (itl_q),
        .page       (page_q),
        .col        (calc_col)
    );

    assign col_o = beat_valid_o ? calc_col : '0;

    // R9
    restart_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (beat_valid_o && col_o == $past(start_col_i)));

    // R5
    page_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (page_q && beat_valid_o && !start_i && !term_i)
            |=> (beat_valid_o && col_o == COL_W'($past(col_o) + 1'b1)));

endmodule

// File: tb/burst_col_gen_tb_top.sv
module burst_col_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [7:0] start_col_i = '0;
    logic [2:0] len_sel_i = '0;
    logic       interleave_i = 1'b0;
    logic       auto_pre_i = 1'b0;
    logic       term_i = 1'b0;
    logic [7:0] col_o;
    logic       beat_valid_o, last_o, pre_req_o;

    int checks = 0;
    int fails = 0;
    string phase = "R1";
    bit finished = 1'b0;

    always #4 clk = ~clk;

    burst_col_gen dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
        .len_sel_i(len_sel_i), .interleave_i(interleave_i), .auto_pre_i(auto_pre_i),
        .term_i(term_i), .col_o(col_o), .beat_valid_o(beat_valid_o),
        .last_o(last_o), .pre_req_o(pre_req_o)
    );

    // behavioural reference model
    bit m_act, m_page, m_itl, m_ap, m_pre;
    int m_base, m_idx, m_len;

    function automatic int len_of(input logic [2:0] code);
        case (code)
            3'd0: return 1;
            3'd1: return 2;
            3'd2: return 4;
            3'd3: return 8;
            3'd7: return 256;
            default: return 1;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_act = 0; m_page = 0; m_itl = 0; m_ap = 0; m_pre = 0;
            m_base = 0; m_idx = 0; m_len = 1;
        end else if (start_i) begin
            m_act = 1; m_base = start_col_i; m_idx = 0;
            m_len = len_of(len_sel_i); m_page = (len_sel_i == 3'd7);
            m_itl = interleave_i; m_ap = auto_pre_i; m_pre = 0;
        end else if (term_i && m_act) begin
            m_act = 0; m_pre = 0;
        end else if (m_act) begin
            if (!m_page && m_idx == m_len - 1) begin
                m_act = 0; m_pre = m_ap;
            end else begin
                m_idx = (m_idx + 1) % 256;
            end
        end else begin
            m_pre = 0;
        end
    end

    function automatic int exp_col();
        int blk;
        if (!m_act) return 0;
        if (m_page) return (m_base + m_idx) % 256;
        if (m_itl) return m_base ^ m_idx;
        blk = m_base - (m_base % m_len);
        return blk + ((m_base % m_len) + m_idx) % m_len;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(col_o == 8'(exp_col()), {phase, " col R2"}, col_o, exp_col());
            chk(beat_valid_o == m_act, {phase, " valid R7"}, beat_valid_o, m_act);
            chk(last_o == (m_act && !m_page && m_idx == m_len - 1),
                {phase, " last R6"}, last_o, (m_act && !m_page && m_idx == m_len - 1));
            chk(pre_req_o == m_pre, {phase, " prereq R10"}, pre_req_o, m_pre);
        end
    end

    task automatic drv(input bit s, input int c, input int l, input bit it,
                       input bit ap, input bit t);
        @(negedge clk);
        start_i = s; start_col_i = 8'(c); len_sel_i = 3'(l);
        interleave_i = it; auto_pre_i = ap; term_i = t;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drv(0, $urandom % 256, $urandom % 8, $urandom % 2, $urandom % 2, 0);
    endtask

    initial begin
        #(8 * 150000);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(col_o == 0 && !beat_valid_o && !last_o && !pre_req_o, "R1 reset outputs", col_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!beat_valid_o && !pre_req_o, "R1 after reset", beat_valid_o, 0);

        phase = "R3 sequential";
        for (int l = 0; l < 4; l++) begin
            drv(1, 8'hFD, l, 0, 0, 0); idle(10);
            drv(1, 8'h42, l, 0, 0, 0); idle(10);
        end
        phase = "R4 interleaved";
        for (int l = 0; l < 4; l++) begin
            drv(1, 8'hB5, l, 1, 0, 0); idle(10);
        end
        phase = "R11 reserved code";
        drv(1, 8'h11, 5, 0, 1, 0); idle(4);
        drv(1, 8'h12, 4, 1, 0, 0); idle(4);

        phase = "R5 full page";
        drv(1, 250, 7, 1, 1, 0); idle(300);
        phase = "R8 terminate page";
        drv(0, 0, 0, 0, 0, 1); idle(4);
        phase = "R8 terminate idle";
        drv(0, 0, 0, 0, 0, 1); drv(0, 0, 0, 0, 0, 1); idle(2);

        phase = "R10 natural precharge";
        drv(1, 8'h20, 2, 0, 1, 0); idle(8);
        drv(1, 8'h21, 0, 0, 1, 0); idle(4);
        phase = "R10 terminated no precharge";
        drv(1, 8'h30, 3, 0, 1, 0); idle(2); drv(0, 0, 0, 0, 0, 1); idle(12);
        drv(1, 8'h31, 1, 0, 1, 0); drv(0, 0, 0, 0, 0, 1); idle(4);
        phase = "R9 restart";
        drv(1, 8'h40, 3, 0, 1, 0); idle(3); drv(1, 8'h9C, 2, 1, 0, 1); idle(8);
        drv(1, 8'h50, 1, 0, 1, 0); drv(0, 0, 0, 0, 0, 0); drv(1, 8'h60, 0, 0, 1, 0); idle(2);
        drv(1, 8'h70, 0, 0, 1, 0); drv(0, 0, 0, 0, 0, 0); drv(1, 8'h77, 1, 0, 0, 0); idle(4);

        phase = "R9 random mix";
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = $urandom % 100;
            drv(r < 12, $urandom % 256, $urandom % 8, $urandom % 2, $urandom % 2,
                ($urandom % 100) < 8);
        end
        idle(20);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule